// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Engine

This block moves a contiguous block of 16-bit words between memory and a single I/O device without the processor touching each word. Software programs a device address, a memory start address and a word count, then writes a start command that also picks the direction. The engine asks for the bus, waits for the grant, moves exactly one word, and hands the bus back. It repeats this once per word until the count runs out. The processor therefore loses one bus cycle per word instead of the whole transfer.

Each word is moved in two steps. The engine first reads the word from the source port into a holding register. It then writes that word to the destination port. Both ports use a valid/ready handshake. While the engine owns the bus it raises an output that stops the processor from recognising interrupts. When the last word is written, a sticky completion interrupt is raised. It stays up until software clears it.

Top module: `dma_cycle_steal`

## Requirements
- R1: After reset the engine is idle and all programmable registers read zero. The bus request and the interrupt are low. The control register (offset 0) reads back bit0 = busy, bit1 = direction and bit2 = interrupt flag. Busy reads 1 from the start command until completion.
- R2: A start command is a write to offset 0 with bit0 = 1. If the count is nonzero, the bus request is asserted in the cycle after the start write. Neither data port is accessed before the grant arrives.
- R3: Each word is read from the source port and then written unchanged to the destination port. Bit1 of the start write sets the direction: 0 moves device to memory, 1 moves memory to device. At most one port is valid at a time, and a valid port keeps its address until ready.
- R4: The memory address register (offset 2) advances by 2 after each word and wraps modulo 2^16. The device address register (offset 1) does not change during a transfer.
- R5: The bus request is dropped for at least one cycle after every word. A transfer of N words issues exactly N separate requests.
- R6: The interrupt-inhibit output is high only while a data port is being accessed. It is high only while the grant is held.
- R7: The count register (offset 3) decrements once per word. When it reaches zero, the interrupt flag is set, busy clears and the bus request is low.
- R8: A start with a count of zero never requests the bus, moves no word and sets the interrupt flag.
- R9: The interrupt flag stays set until a write to offset 0 with bit2 = 1. Control writes with bit2 = 0 leave it set.
- R10: While busy, writes to offsets 1 to 3 and further start commands are ignored. The direction also stays fixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register offset |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data (combinational) |
| busReq | output | 1 | Bus ownership request |
| busGrant | input | 1 | Bus ownership grant |
| intInhibit | output | 1 | Suppress interrupt recognition |
| irq | output | 1 | Completion interrupt (sticky) |
| memValid | output | 1 | Memory access valid |
| memWrite | output | 1 | Memory access is a write |
| memAddr | output | 16 | Memory byte address |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data |
| memReady | input | 1 | Memory access complete |
| ioValid | output | 1 | Device access valid |
| ioWrite | output | 1 | Device access is a write |
| ioAddr | output | 8 | Device address |
| ioWdata | output | 16 | Device write data |
| ioRdata | input | 16 | Device read data |
| ioReady | input | 1 | Device access complete |

## Verification
A wrong state in the sequencer shows up within a cycle or two. The symptoms are a bus request that stays up across a word boundary, a port access without the inhibit output, or a count that runs past zero. A wrong datapath register shows up in the next write on the destination port, as a shifted address or a stale word. It also shows up in the register readback after completion. Both are checked at every completed transfer, and the bus protocol is checked on every cycle.

// File: rtl/dma_cs_pkg.sv
package dma_cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_FETCH,
    ST_STORE,
    ST_RELEASE,
    ST_DONE
  } dmaState_t;

  typedef struct packed {
    logic cfgOpen;    // registers may be written
    logic latchData;  // capture source word
    logic stepWord;   // advance address, decrement count
    logic setIrq;     // raise completion flag
  } dpStrobe_t;

  localparam logic [1:0] REG_CTRL    = 2'd0;
  localparam logic [1:0] REG_IOADDR  = 2'd1;
  localparam logic [1:0] REG_MEMADDR = 2'd2;
  localparam logic [1:0] REG_COUNT   = 2'd3;

  localparam int CTRL_START = 0;
  localparam int CTRL_DIR   = 1;
  localparam int CTRL_IRQ   = 2;

endpackage

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_cs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       countZero,
  input  logic       busGrant,
  input  logic       fetchDone,
  input  logic       storeDone,
  output logic       busReq,
  output logic       intInhibit,
  output logic       fetchPhase,
  output logic       storePhase,
  output logic       busy,
  output dpStrobe_t  strobe
);

  dmaState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:    if (startReq) nextState = countZero ? ST_DONE : ST_REQ;
      ST_REQ:     if (busGrant) nextState = ST_FETCH;
      ST_FETCH:   if (fetchDone) nextState = ST_STORE;
      ST_STORE:   if (storeDone) nextState = ST_RELEASE;
      ST_RELEASE: nextState = countZero ? ST_DONE : ST_REQ;
      ST_DONE:    nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  assign fetchPhase = (state == ST_FETCH);
  assign storePhase = (state == ST_STORE);
  assign busReq     = (state == ST_REQ) || fetchPhase || storePhase;
  assign intInhibit = fetchPhase || storePhase;
  assign busy       = (state != ST_IDLE);

  always_comb begin
    strobe           = '0;
    strobe.cfgOpen   = (state == ST_IDLE);
    strobe.latchData = fetchPhase && fetchDone;
    strobe.stepWord  = storePhase && storeDone;
    strobe.setIrq    = (state == ST_DONE);
  end

endmodule

// File: rtl/dma_datapath.sv
module dma_datapath
  import dma_cs_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 16,
  parameter int IO_W      = 8,
  parameter int CNT_W     = 16,
  parameter int ADDR_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              fetchPhase,
  input  logic              storePhase,
  input  logic              busy,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              startReq,
  output logic              countZero,
  output logic              fetchDone,
  output logic              storeDone,
  output logic              irq,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady,
  output logic              ioValid,
  output logic              ioWrite,
  output logic [IO_W-1:0]   ioAddr,
  output logic [DATA_W-1:0] ioWdata,
  input  logic [DATA_W-1:0] ioRdata,
  input  logic              ioReady
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ADDR_STEP);
  localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

  logic [IO_W-1:0]   ioAddrReg;
  logic [ADDR_W-1:0] memAddrReg;
  logic [CNT_W-1:0]  countReg;
  logic [DATA_W-1:0] holdData;
  logic              dirReg;     // 1: memory to device
  logic              irqFlag;
  logic              ctrlWr;

  assign ctrlWr   = regWe && (regAddr == REG_CTRL);
  assign startReq = ctrlWr && regWdata[CTRL_START];
  assign countZero = (countReg == '0);

  // configuration registers, open only while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioAddrReg  <= '0;
      memAddrReg <= '0;
      countReg   <= '0;
      dirReg     <= 1'b0;
    end else if (strobe.cfgOpen) begin
      if (regWe) begin
        unique case (regAddr)
          REG_CTRL:    dirReg     <= regWdata[CTRL_DIR];
          REG_IOADDR:  ioAddrReg  <= IO_W'(regWdata);
          REG_MEMADDR: memAddrReg <= ADDR_W'(regWdata);
          REG_COUNT:   countReg   <= CNT_W'(regWdata);
          default: ;
        endcase
      end
    end else if (strobe.stepWord) begin
      memAddrReg <= memAddrReg + STEP;
      countReg   <= countReg - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 holdData <= '0;
    else if (strobe.latchData) holdData <= dirReg ? memRdata : ioRdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  irqFlag <= 1'b0;
    else if (strobe.setIrq)                     irqFlag <= 1'b1;
    else if (ctrlWr && regWdata[CTRL_IRQ])      irqFlag <= 1'b0;
  end

  // port steering by direction
  assign memValid  = (fetchPhase && dirReg) || (storePhase && !dirReg);
  assign memWrite  = storePhase && !dirReg;
  assign ioValid   = (fetchPhase && !dirReg) || (storePhase && dirReg);
  assign ioWrite   = storePhase && dirReg;
  assign memAddr   = memAddrReg;
  assign ioAddr    = ioAddrReg;
  assign memWdata  = holdData;
  assign ioWdata   = holdData;
  assign fetchDone = fetchPhase && (dirReg ? memReady : ioReady);
  assign storeDone = storePhase && (dirReg ? ioReady : memReady);
  assign irq       = irqFlag;

  always_comb begin
    unique case (regAddr)
      REG_CTRL:    regRdata = DATA_W'({irqFlag, dirReg, busy});
      REG_IOADDR:  regRdata = DATA_W'(ioAddrReg);
      REG_MEMADDR: regRdata = DATA_W'(memAddrReg);
      default:     regRdata = DATA_W'(countReg);
    endcase
  end

endmodule

// File: rtl/dma_cycle_steal.sv
module dma_cycle_steal
  import dma_cs_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 16,
  parameter int IO_W      = 8,
  parameter int CNT_W     = 16,
  parameter int ADDR_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              busReq,
  input  logic              busGrant,
  output logic              intInhibit,
  output logic              irq,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady,
  output logic              ioValid,
  output logic              ioWrite,
  output logic [IO_W-1:0]   ioAddr,
  output logic [DATA_W-1:0] ioWdata,
  input  logic [DATA_W-1:0] ioRdata,
  input  logic              ioReady
);

  dpStrobe_t strobe;
  logic startReq, countZero, fetchDone, storeDone;
  logic fetchPhase, storePhase, busy;

  dma_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .countZero  (countZero),
    .busGrant   (busGrant),
    .fetchDone  (fetchDone),
    .storeDone  (storeDone),
    .busReq     (busReq),
    .intInhibit (intInhibit),
    .fetchPhase (fetchPhase),
    .storePhase (storePhase),
    .busy       (busy),
    .strobe     (strobe)
  );

  dma_datapath #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .IO_W      (IO_W),
    .CNT_W     (CNT_W),
    .ADDR_STEP (ADDR_STEP)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .fetchPhase (fetchPhase),
    .storePhase (storePhase),
    .busy       (busy),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .startReq   (startReq),
    .countZero  (countZero),
    .fetchDone  (fetchDone),
    .storeDone  (storeDone),
    .irq        (irq),
    .memValid   (memValid),
    .memWrite   (memWrite),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memRdata   (memRdata),
    .memReady   (memReady),
    .ioValid    (ioValid),
    .ioWrite    (ioWrite),
    .ioAddr     (ioAddr),
    .ioWdata    (ioWdata),
    .ioRdata    (ioRdata),
    .ioReady    (ioReady)
  );

endmodule

// File: rtl/dma_cs_checker.sv
module dma_cs_checker #(
  parameter int ADDR_W = 16,
  parameter int IO_W   = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              busReq,
  input logic              busGrant,
  input logic              intInhibit,
  input logic              irq,
  input logic              memValid,
  input logic              memReady,
  input logic              memWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic              ioValid,
  input logic              ioReady,
  input logic              ioWrite,
  input logic [IO_W-1:0]   ioAddr
);

  logic pastBusy;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastBusy <= 1'b0;
    else       pastBusy <= busy;
  end

  p_no_req_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busReq);

  p_one_port_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memValid, ioValid}));

  p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr)));

  p_io_fixed_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && pastBusy) |-> $stable(ioAddr));

  p_release_after_word_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((memValid && memReady && memWrite) || (ioValid && ioReady && ioWrite)) |=> !busReq);

  p_inhibit_granted_r6: assert property (@(posedge clk) disable iff (!rstN)
    intInhibit |-> (busGrant && busReq));

  p_access_inhibited_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memValid || ioValid) |-> intInhibit);

  p_irq_quiet_bus_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (!busReq && !busy));

endmodule

bind dma_cycle_steal dma_cs_checker #(.ADDR_W(ADDR_W), .IO_W(IO_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .busReq     (busReq),
  .busGrant   (busGrant),
  .intInhibit (intInhibit),
  .irq        (irq),
  .memValid   (memValid),
  .memReady   (memReady),
  .memWrite   (memWrite),
  .memAddr    (memAddr),
  .ioValid    (ioValid),
  .ioReady    (ioReady),
  .ioWrite    (ioWrite),
  .ioAddr     (ioAddr)
);

// File: tb/dma_cycle_steal_tb_top.sv
`timescale 1ns/1ps
module dma_cycle_steal_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        busReq, intInhibit, irq;
  logic        busGrant = 1'b0;
  logic        memValid, memWrite, ioValid, ioWrite;
  logic [15:0] memAddr, memWdata, ioWdata, memRdata, ioRdata;
  logic [7:0]  ioAddr;
  logic        memReady = 1'b0;
  logic        ioReady = 1'b0;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  dma_cycle_steal dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .busReq(busReq),
    .busGrant(busGrant), .intInhibit(intInhibit), .irq(irq),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady),
    .ioValid(ioValid), .ioWrite(ioWrite), .ioAddr(ioAddr),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .ioReady(ioReady)
  );

  // bus-side models
  function automatic logic [15:0] memFunc(input logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction

  logic [7:0]  ioRdCnt = 8'd0;
  logic        ioPending = 1'b0;
  logic        grantEnable = 1'b1;
  logic        prevReq = 1'b0;
  int          reqRises = 0;
  int          protoErr = 0;
  int          logN = 0;
  logic        logIsMem [64];
  logic [15:0] logAddr [64];
  logic [15:0] logData [64];

  assign memRdata = memFunc(memAddr);
  assign ioRdata  = {ioAddr, ioRdCnt};

  always @(negedge clk) begin
    if (ioPending) ioRdCnt = ioRdCnt + 8'd1;
    if (busReq && !prevReq) reqRises++;
    prevReq = busReq;
    if ((memValid || ioValid) && !intInhibit) protoErr++;
    if (intInhibit && !busGrant) protoErr++;
    busGrant = busReq && grantEnable && (busGrant || ($urandom % 3 == 0));
    memReady = memValid && ($urandom % 2 == 0);
    ioReady  = ioValid && ($urandom % 2 == 0);
    if (memReady && memWrite && logN < 64) begin
      logIsMem[logN] = 1'b1; logAddr[logN] = memAddr; logData[logN] = memWdata; logN++;
    end
    if (ioReady && ioWrite && logN < 64) begin
      logIsMem[logN] = 1'b0; logAddr[logN] = {8'h00, ioAddr}; logData[logN] = ioWdata; logN++;
    end
    ioPending = ioValid && ioReady && !ioWrite;
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic waitIrq();
    for (int n = 0; n < 4000 && !irq; n++) @(negedge clk);
  endtask

  task automatic checkWords(input logic dir, input logic [7:0] ioA, input logic [15:0] memA,
                            input int cnt, input logic [7:0] ioBase);
    chk("R3 word count moved", logN, cnt);
    for (int k = 0; k < cnt && k < logN; k++) begin
      if (!dir) begin
        chk("R3 dev->mem target is memory", {31'd0, logIsMem[k]}, 1);
        chk("R4 memory address per word", {16'd0, logAddr[k]}, {16'd0, 16'(memA + 16'(2 * k))});
        chk("R3 dev->mem data", {16'd0, logData[k]}, {16'd0, ioA, 8'(ioBase + 8'(k))});
      end else begin
        chk("R3 mem->dev target is device", {31'd0, logIsMem[k]}, 0);
        chk("R4 device address fixed", {16'd0, logAddr[k]}, {24'd0, ioA});
        chk("R3 mem->dev data", {16'd0, logData[k]}, {16'd0, memFunc(16'(memA + 16'(2 * k)))});
      end
    end
  endtask

  task automatic finishAndClear(input string tag);
    logic [15:0] v;
    repeat (5) @(negedge clk);
    chk({"R9 irq sticky ", tag}, {31'd0, irq}, 1);
    regWrite(2'd0, 16'h0000);
    chk({"R9 irq kept by write without clear ", tag}, {31'd0, irq}, 1);
    regWrite(2'd0, 16'h0004);
    regRead(2'd0, v);
    chk({"R9 irq cleared ", tag}, {31'd0, irq, v[2]}, 0);
  endtask

  task automatic runXfer(input logic dir, input logic [7:0] ioA, input logic [15:0] memA,
                         input logic [15:0] cnt, input string tag);
    logic [15:0] v;
    logic [7:0]  ioBase;
    regWrite(2'd1, {8'd0, ioA});
    regWrite(2'd2, memA);
    regWrite(2'd3, cnt);
    logN = 0; reqRises = 0; protoErr = 0; ioBase = ioRdCnt;
    regWrite(2'd0, {14'd0, dir, 1'b1});
    waitIrq();
    chk({"R7 irq raised ", tag}, {31'd0, irq}, 1);
    regRead(2'd0, v);
    chk({"R7 busy clear at end ", tag}, {31'd0, v[0]}, 0);
    chk({"R1 direction readback ", tag}, {31'd0, v[1]}, {31'd0, dir});
    regRead(2'd3, v);
    chk({"R7 count reached zero ", tag}, {16'd0, v}, 0);
    regRead(2'd2, v);
    chk({"R4 final memory address ", tag}, {16'd0, v}, {16'd0, 16'(memA + 16'(2 * cnt))});
    regRead(2'd1, v);
    chk({"R4 device address unchanged ", tag}, {16'd0, v}, {24'd0, ioA});
    chk({"R5 one request per word ", tag}, reqRises, {16'd0, cnt});
    chk({"R6 port access only inhibited and granted ", tag}, protoErr, 0);
    checkWords(dir, ioA, memA, int'(cnt), ioBase);
    finishAndClear(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    regRead(2'd0, v); chk("R1 control after reset", {16'd0, v}, 0);
    regRead(2'd1, v); chk("R1 device address after reset", {16'd0, v}, 0);
    regRead(2'd2, v); chk("R1 memory address after reset", {16'd0, v}, 0);
    regRead(2'd3, v); chk("R1 count after reset", {16'd0, v}, 0);
    chk("R1 outputs quiet after reset", {29'd0, busReq, irq, intInhibit}, 0);

    // directed corner cases
    runXfer(1'b0, 8'h12, 16'h0040, 16'd1, "single in");
    runXfer(1'b1, 8'h7E, 16'h0200, 16'd1, "single out");
    logN = 0; reqRises = 0;
    regWrite(2'd3, 16'd0);
    regWrite(2'd0, 16'h0001);
    waitIrq();
    repeat (3) @(negedge clk);
    chk("R8 zero count raises irq", {31'd0, irq}, 1);
    chk("R8 zero count no request", reqRises, 0);
    chk("R8 zero count no words", logN, 0);
    finishAndClear("zero");
    runXfer(1'b0, 8'hA1, 16'hFFFE, 16'd2, "wrap");

    // start holds request without grant, busy ignores writes
    grantEnable = 1'b0;
    regWrite(2'd1, 16'h0033);
    regWrite(2'd2, 16'h0100);
    regWrite(2'd3, 16'd3);
    logN = 0; reqRises = 0;
    regWrite(2'd0, 16'h0003);
    chk("R2 request one cycle after start", {31'd0, busReq}, 1);
    chk("R2 no port access before grant", {30'd0, memValid, ioValid}, 0);
    regRead(2'd0, v); chk("R1 busy while waiting", {31'd0, v[0]}, 1);
    regWrite(2'd1, 16'h00EE);
    regWrite(2'd2, 16'h0800);
    regWrite(2'd3, 16'd50);
    regWrite(2'd0, 16'h0001);
    regRead(2'd1, v); chk("R10 device address locked", {16'd0, v}, 32'h33);
    regRead(2'd2, v); chk("R10 memory address locked", {16'd0, v}, 32'h100);
    regRead(2'd3, v); chk("R10 count locked", {16'd0, v}, 3);
    regRead(2'd0, v); chk("R10 direction locked", {31'd0, v[1]}, 1);
    chk("R2 still no access without grant", {30'd0, memValid, ioValid}, 0);
    grantEnable = 1'b1;
    waitIrq();
    chk("R10 irq after locked run", {31'd0, irq}, 1);
    checkWords(1'b1, 8'h33, 16'h0100, 3, 8'h00);
    finishAndClear("locked");

    // random transfers
    for (int i = 0; i < 10; i++) begin
      logic        d;
      logic [7:0]  ioA;
      logic [15:0] memA;
      logic [15:0] cnt;
      d    = 1'($urandom % 2);
      ioA  = 8'($urandom);
      memA = 16'($urandom) & 16'hFFFE;
      cnt  = 16'(1 + $urandom % 6);
      runXfer(d, ioA, memA, cnt, "random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule